// File: doc/BRIEF.md
# CFI Control-Field CSR Slice

This block holds the control-flow-integrity (CFI) enable bits and the saved landing-pad-state bits that are spread over several control and status register views of a processor core. A core's CSR unit sends it reads and writes with an address, write data and the current virtualization flag. The block returns read data in which every field that is not enabled is masked to zero. A second input interface reports trap entries, so the block can record whether a landing pad was expected when the trap was taken.

The fields are gated in layers. The machine-level enable for lower privileges gates the hypervisor-level enable and the host user/supervisor fields. The machine enable and the hypervisor enable together gate the guest (virtual supervisor) copy of those fields. When a field is gated off, it reads as zero, CSR writes to it have no effect, and trap updates to it have no effect. The supervisor status view is an alias of the machine status fields. While virtualization is active, the same address reaches the guest copy instead. A machine security-config view holds an M-mode forward-edge enable and a legal-value-only index that selects the shadow-stack PMP entry.

Top module: `cfi_ctrl_csr`

## Requirements
- R1: After synchronous reset, every field is zero, so every view reads as all zeros.
- R2: The machine env-config view stores bit 60 (lower-privilege CFI enable, called M-EN) and bit 59 (supervisor forward-edge enable). All other bits of that view read as zero.
- R3: The hypervisor env-config view stores bit 59 freely. Its bit 60 (H-EN) reads as zero while M-EN is 0, and writes to bit 60 are ignored while M-EN is 0.
- R4: In the machine status view, bit 23 (user forward), bit 24 (user backward) and bit 25 (supervisor saved-landing-pad) read as zero and ignore writes while M-EN is 0. Bit 26 (machine saved-landing-pad) is always writable.
- R5: With the virtualization flag at 0, the supervisor status view reads and writes the same bits 23–25 as the machine status view, under the same M-EN masking. Bit 26 is not visible through it.
- R6: The guest status bits 23–25 are a separate bank. It is reached through the supervisor status address with the virtualization flag at 1, or through the guest status address. It reads as zero and ignores writes unless M-EN and H-EN are both 1.
- R7: A trap into M-mode stores the expected-landing-pad input (1 = expected, 0 = none) into machine status bit 26.
- R8: A trap into S-mode with the virtualization flag at 0 stores the flag into machine status bit 25, provided M-EN is 1. With the virtualization flag at 1, it stores the flag into guest bit 25, provided M-EN and H-EN are both 1.
- R9: When a trap and a CSR write to the same saved-landing-pad bit fall in one cycle, the trap value is kept. The other bits of that write still take effect.
- R10: In the machine security-config view, bit 9 (M-mode forward-edge enable) is freely writable. Bits 8:3 (shadow-stack PMP index) take a written value only if it is below PMP_ENTRIES (16 by default); otherwise they keep their old value.
- R11: An address outside the six views reads as zero, and a write to it changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_virt | input | 1 | Virtualization flag of the access |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | Masked read data for csr_addr (combinational) |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_to_m | input | 1 | 1: trap targets M-mode, 0: trap targets S-mode |
| trap_virt | input | 1 | S-mode trap targets the guest supervisor |
| trap_lp_exp | input | 1 | A landing pad was expected at the interrupted privilege |

## Verification
The main function is exercised by sweeping all four combinations of M-EN and H-EN. Under each combination, all-ones data is written through the machine, supervisor and guest status views, and every view is compared with a behavioural reference model. This separates the host masking layer from the guest masking layer. It also separates the alias between the machine and supervisor views from the independent guest bank. Clearing M-EN after H-EN has been set shows that H-EN is masked on read and not lost in storage. Traps are issued with each target and each expected-landing-pad value, both alone and together with a conflicting write in the same cycle. Illegal PMP index values and unlisted addresses show that the state is left unchanged.

// File: rtl/cfi_csr_pkg.sv
package cfi_csr_pkg;

    localparam int XLEN       = 64;
    localparam int B_LOWER_EN = 60;
    localparam int B_SUP_FWD  = 59;
    localparam int B_U_FWD    = 23;
    localparam int B_U_BWD    = 24;
    localparam int B_S_PREV   = 25;
    localparam int B_M_PREV   = 26;
    localparam int B_M_FWD    = 9;
    localparam int B_PMP_LO   = 3;
    localparam int PMP_W      = 6;

    typedef enum logic [2:0] {
        VW_NONE,
        VW_MENV,
        VW_HENV,
        VW_MSTAT,
        VW_SSTAT,
        VW_GSTAT,
        VW_MSEC
    } view_e;

    typedef struct packed {
        logic fwd;
        logic bwd;
        logic s_prev;
    } user_fields_t;

    typedef struct packed {
        logic lower_en;
        logic sup_fwd;
    } env_t;

    typedef struct packed {
        logic             m_fwd;
        logic [PMP_W-1:0] pmp_sel;
    } msec_t;

    function automatic user_fields_t pick_user(input logic [XLEN-1:0] d);
        user_fields_t u;
        u.fwd    = d[B_U_FWD];
        u.bwd    = d[B_U_BWD];
        u.s_prev = d[B_S_PREV];
        return u;
    endfunction

    function automatic logic [XLEN-1:0] place_user(input user_fields_t u, input logic gate);
        logic [XLEN-1:0] d;
        d = '0;
        d[B_U_FWD]  = u.fwd & gate;
        d[B_U_BWD]  = u.bwd & gate;
        d[B_S_PREV] = u.s_prev & gate;
        return d;
    endfunction

endpackage

// File: rtl/cfi_addr_decode.sv
module cfi_addr_decode
    import cfi_csr_pkg::*;
#(
    parameter logic [11:0] A_MENV  = 12'h30A,
    parameter logic [11:0] A_HENV  = 12'h60A,
    parameter logic [11:0] A_MSTAT = 12'h300,
    parameter logic [11:0] A_SSTAT = 12'h100,
    parameter logic [11:0] A_GSTAT = 12'h200,
    parameter logic [11:0] A_MSEC  = 12'h747
) (
    input  logic [11:0] addr,
    input  logic        virt,
    output view_e       view
);
    always_comb begin
        unique case (addr)
            A_MENV:  view = VW_MENV;
            A_HENV:  view = VW_HENV;
            A_MSTAT: view = VW_MSTAT;
            A_SSTAT: view = virt ? VW_GSTAT : VW_SSTAT;
            A_GSTAT: view = VW_GSTAT;
            A_MSEC:  view = VW_MSEC;
            default: view = VW_NONE;
        endcase
    end
endmodule

// File: rtl/cfi_env_regs.sv
module cfi_env_regs
    import cfi_csr_pkg::*;
#(
    parameter int PMP_ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_menv,
    input  logic            wr_henv,
    input  logic            wr_msec,
    input  logic [XLEN-1:0] wdata,
    output env_t            menv_q,
    output env_t            henv_q,
    output msec_t           msec_q
);
    localparam int SEL_MAX = PMP_ENTRIES;

    logic [PMP_W-1:0] new_sel;
    logic             sel_legal;

    assign new_sel   = wdata[B_PMP_LO +: PMP_W];
    assign sel_legal = (int'(new_sel) < SEL_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            menv_q <= '0;
            henv_q <= '0;
            msec_q <= '0;
        end else begin
            if (wr_menv) begin
                menv_q.lower_en <= wdata[B_LOWER_EN];
                menv_q.sup_fwd  <= wdata[B_SUP_FWD];
            end
            if (wr_henv) begin
                henv_q.sup_fwd <= wdata[B_SUP_FWD];
                if (menv_q.lower_en)
                    henv_q.lower_en <= wdata[B_LOWER_EN];
            end
            if (wr_msec) begin
                msec_q.m_fwd <= wdata[B_M_FWD];
                if (sel_legal)
                    msec_q.pmp_sel <= new_sel;
            end
        end
    end

    // R10: index stays within the legal range
    p_pmp_legal_r10: assert property (@(posedge clk) disable iff (rst)
        int'(msec_q.pmp_sel) < SEL_MAX);

    // R3: hypervisor enable cannot move while the machine enable is clear
    p_henv_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !menv_q.lower_en |=> $stable(henv_q.lower_en));
endmodule

// File: rtl/cfi_user_bank.sv
module cfi_user_bank
    import cfi_csr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         gate_en,
    input  logic         wr_en,
    input  user_fields_t wr_val,
    input  logic         trap_hit,
    input  logic         trap_lp,
    output user_fields_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (gate_en) begin
            if (wr_en) begin
                q.fwd <= wr_val.fwd;
                q.bwd <= wr_val.bwd;
            end
            if (trap_hit)
                q.s_prev <= trap_lp;
            else if (wr_en)
                q.s_prev <= wr_val.s_prev;
        end
    end

    // R4 / R6: a gated-off bank does not change
    p_gate_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !gate_en |=> $stable(q));

    // R8 / R9: an enabled trap lands its flag, whatever the write did
    p_trap_save_r8: assert property (@(posedge clk) disable iff (rst)
        (gate_en && trap_hit) |=> (q.s_prev == $past(trap_lp)));
endmodule

// File: rtl/cfi_status_regs.sv
module cfi_status_regs
    import cfi_csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            m_en,
    input  logic            h_en,
    input  logic            wr_host,
    input  logic            wr_guest,
    input  logic            wr_mprev,
    input  logic [XLEN-1:0] wdata,
    input  logic            trap_valid,
    input  logic            trap_to_m,
    input  logic            trap_virt,
    input  logic            trap_lp_exp,
    output user_fields_t    host_q,
    output user_fields_t    guest_q,
    output logic            m_prev_q
);
    localparam int NBANK = 2;

    user_fields_t wr_val;
    logic [NBANK-1:0] gate_v, wr_v, hit_v;
    user_fields_t     q_v [NBANK];
    logic             mtrap;

    assign wr_val = pick_user(wdata);
    assign mtrap  = trap_valid && trap_to_m;

    assign gate_v = {m_en && h_en, m_en};
    assign wr_v   = {wr_guest, wr_host};
    assign hit_v  = {trap_valid && !trap_to_m && trap_virt,
                     trap_valid && !trap_to_m && !trap_virt};

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        cfi_user_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .gate_en  (gate_v[b]),
            .wr_en    (wr_v[b]),
            .wr_val   (wr_val),
            .trap_hit (hit_v[b]),
            .trap_lp  (trap_lp_exp),
            .q        (q_v[b])
        );
    end

    assign host_q  = q_v[0];
    assign guest_q = q_v[1];

    always_ff @(posedge clk) begin
        if (rst)
            m_prev_q <= 1'b0;
        else if (mtrap)
            m_prev_q <= trap_lp_exp;
        else if (wr_mprev)
            m_prev_q <= wdata[B_M_PREV];
    end

    // R7 / R9: a machine trap stores its flag
    p_mtrap_save_r7: assert property (@(posedge clk) disable iff (rst)
        mtrap |=> (m_prev_q == $past(trap_lp_exp)));
endmodule

// File: rtl/cfi_ctrl_csr.sv
module cfi_ctrl_csr
    import cfi_csr_pkg::*;
#(
    parameter logic [11:0] A_MENV      = 12'h30A,
    parameter logic [11:0] A_HENV      = 12'h60A,
    parameter logic [11:0] A_MSTAT     = 12'h300,
    parameter logic [11:0] A_SSTAT     = 12'h100,
    parameter logic [11:0] A_GSTAT     = 12'h200,
    parameter logic [11:0] A_MSEC      = 12'h747,
    parameter int          PMP_ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic        csr_virt,
    input  logic [63:0] csr_wdata,
    output logic [63:0] csr_rdata,
    input  logic        trap_valid,
    input  logic        trap_to_m,
    input  logic        trap_virt,
    input  logic        trap_lp_exp
);
    view_e        view;
    env_t         menv_q, henv_q;
    msec_t        msec_q;
    user_fields_t host_q, guest_q;
    logic         m_prev_q;
    logic         m_en, h_en;

    cfi_addr_decode #(
        .A_MENV(A_MENV), .A_HENV(A_HENV), .A_MSTAT(A_MSTAT),
        .A_SSTAT(A_SSTAT), .A_GSTAT(A_GSTAT), .A_MSEC(A_MSEC)
    ) u_dec (
        .addr (csr_addr),
        .virt (csr_virt),
        .view (view)
    );

    cfi_env_regs #(.PMP_ENTRIES(PMP_ENTRIES)) u_env (
        .clk     (clk),
        .rst     (rst),
        .wr_menv (csr_we && view == VW_MENV),
        .wr_henv (csr_we && view == VW_HENV),
        .wr_msec (csr_we && view == VW_MSEC),
        .wdata   (csr_wdata),
        .menv_q  (menv_q),
        .henv_q  (henv_q),
        .msec_q  (msec_q)
    );

    assign m_en = menv_q.lower_en;
    assign h_en = henv_q.lower_en & m_en;

    cfi_status_regs u_stat (
        .clk         (clk),
        .rst         (rst),
        .m_en        (m_en),
        .h_en        (h_en),
        .wr_host     (csr_we && (view == VW_MSTAT || view == VW_SSTAT)),
        .wr_guest    (csr_we && view == VW_GSTAT),
        .wr_mprev    (csr_we && view == VW_MSTAT),
        .wdata       (csr_wdata),
        .trap_valid  (trap_valid),
        .trap_to_m   (trap_to_m),
        .trap_virt   (trap_virt),
        .trap_lp_exp (trap_lp_exp),
        .host_q      (host_q),
        .guest_q     (guest_q),
        .m_prev_q    (m_prev_q)
    );

    always_comb begin
        csr_rdata = '0;
        unique case (view)
            VW_MENV: begin
                csr_rdata[B_LOWER_EN] = menv_q.lower_en;
                csr_rdata[B_SUP_FWD]  = menv_q.sup_fwd;
            end
            VW_HENV: begin
                csr_rdata[B_LOWER_EN] = h_en;
                csr_rdata[B_SUP_FWD]  = henv_q.sup_fwd;
            end
            VW_MSTAT: begin
                csr_rdata           = place_user(host_q, m_en);
                csr_rdata[B_M_PREV] = m_prev_q;
            end
            VW_SSTAT: csr_rdata = place_user(host_q, m_en);
            VW_GSTAT: csr_rdata = place_user(guest_q, h_en);
            VW_MSEC: begin
                csr_rdata[B_M_FWD]            = msec_q.m_fwd;
                csr_rdata[B_PMP_LO +: PMP_W]  = msec_q.pmp_sel;
            end
            default: csr_rdata = '0;
        endcase
    end

    // R3: hypervisor enable reads zero with the machine enable clear
    p_henv_read_r3: assert property (@(posedge clk) disable iff (rst)
        (view == VW_HENV && !menv_q.lower_en) |-> !csr_rdata[B_LOWER_EN]);

    // R6: guest bank reads zero unless both enables are set
    p_guest_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (view == VW_GSTAT && !(menv_q.lower_en && henv_q.lower_en)) |-> (csr_rdata == '0));

    // R11: unlisted addresses read zero
    p_unlisted_r11: assert property (@(posedge clk) disable iff (rst)
        (view == VW_NONE) |-> (csr_rdata == '0));
endmodule

// File: tb/cfi_ctrl_csr_test.sv
module cfi_ctrl_csr_test;
    localparam logic [11:0] A_MENV  = 12'h30A;
    localparam logic [11:0] A_HENV  = 12'h60A;
    localparam logic [11:0] A_MSTAT = 12'h300;
    localparam logic [11:0] A_SSTAT = 12'h100;
    localparam logic [11:0] A_GSTAT = 12'h200;
    localparam logic [11:0] A_MSEC  = 12'h747;
    localparam logic [11:0] A_JUNK  = 12'h7FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_virt = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        trap_valid = 1'b0, trap_to_m = 1'b0, trap_virt = 1'b0, trap_lp_exp = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic m_en, m_sf, h_en, h_sf, uf, ub, sp, mp, gf, gb, gp, mf;
    logic [5:0] psel;

    always #4 clk = ~clk;

    cfi_ctrl_csr uut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_virt(csr_virt), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trap_valid(trap_valid), .trap_to_m(trap_to_m),
        .trap_virt(trap_virt), .trap_lp_exp(trap_lp_exp)
    );

    task automatic model_reset();
        {m_en, m_sf, h_en, h_sf, uf, ub, sp, mp, gf, gb, gp, mf} = '0;
        psel = '0;
    endtask

    function automatic logic [63:0] model_read(input logic [11:0] a, input logic v);
        logic [63:0] d;
        d = '0;
        if (a == A_MENV) begin
            d[60] = m_en; d[59] = m_sf;
        end else if (a == A_HENV) begin
            d[60] = h_en & m_en; d[59] = h_sf;
        end else if (a == A_MSTAT) begin
            d[23] = uf & m_en; d[24] = ub & m_en; d[25] = sp & m_en; d[26] = mp;
        end else if ((a == A_SSTAT && v) || a == A_GSTAT) begin
            d[23] = gf & m_en & h_en; d[24] = gb & m_en & h_en; d[25] = gp & m_en & h_en;
        end else if (a == A_SSTAT) begin
            d[23] = uf & m_en; d[24] = ub & m_en; d[25] = sp & m_en;
        end else if (a == A_MSEC) begin
            d[9] = mf; d[8:3] = psel;
        end
        return d;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic v, input logic [63:0] d,
                               input logic keep_sp, input logic keep_mp, input logic keep_gp);
        logic ge;
        ge = m_en & h_en;
        if (a == A_MENV) begin
            m_en = d[60]; m_sf = d[59];
        end else if (a == A_HENV) begin
            h_sf = d[59];
            if (m_en) h_en = d[60];
        end else if (a == A_MSTAT || (a == A_SSTAT && !v)) begin
            if (m_en) begin
                uf = d[23]; ub = d[24];
                if (!keep_sp) sp = d[25];
            end
            if (a == A_MSTAT && !keep_mp) mp = d[26];
        end else if ((a == A_SSTAT && v) || a == A_GSTAT) begin
            if (ge) begin
                gf = d[23]; gb = d[24];
                if (!keep_gp) gp = d[25];
            end
        end else if (a == A_MSEC) begin
            mf = d[9];
            if (d[8:3] < 6'd16) psel = d[8:3];
        end
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic v);
        @(negedge clk);
        csr_addr = a; csr_virt = v;
        #1;
        chk(tag, csr_rdata, model_read(a, v));
    endtask

    task automatic wr(input logic [11:0] a, input logic v, input logic [63:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_virt = v; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
        model_write(a, v, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic check_all(input string tag);
        rd_chk({tag, " menv"},  A_MENV,  1'b0);
        rd_chk({tag, " henv"},  A_HENV,  1'b0);
        rd_chk({tag, " mstat"}, A_MSTAT, 1'b0);
        rd_chk({tag, " sstat"}, A_SSTAT, 1'b0);
        rd_chk({tag, " sstat-v"}, A_SSTAT, 1'b1);
        rd_chk({tag, " gstat"}, A_GSTAT, 1'b0);
        rd_chk({tag, " msec"},  A_MSEC,  1'b0);
    endtask

    task automatic trap(input logic to_m, input logic v, input logic lp);
        @(negedge clk);
        trap_valid = 1'b1; trap_to_m = to_m; trap_virt = v; trap_lp_exp = lp;
        @(negedge clk);
        trap_valid = 1'b0;
        if (to_m) mp = lp;
        else if (!v && m_en) sp = lp;
        else if (v && m_en && h_en) gp = lp;
    endtask

    task automatic t_reset();
        check_all("R1 reset");
    endtask

    task automatic t_menv();
        wr(A_MENV, 1'b0, '1);
        chk("R2 menv only 60/59", model_read(A_MENV, 1'b0), 64'h1800_0000_0000_0000);
        rd_chk("R2 menv readback", A_MENV, 1'b0);
        wr(A_MENV, 1'b0, 64'h0800_0000_0000_0000);
        rd_chk("R2 menv partial", A_MENV, 1'b0);
    endtask

    task automatic t_layers();
        for (int c = 0; c < 4; c++) begin
            logic me, he;
            me = c[0]; he = c[1];
            wr(A_MENV, 1'b0, 64'(me) << 60);
            wr(A_HENV, 1'b0, (64'(he) << 60) | (64'(c[0]) << 59));
            wr(A_MSTAT, 1'b0, 64'h0000_0000_0780_0000);
            check_all("R4 mstat write");
            wr(A_SSTAT, 1'b0, 64'h0000_0000_0100_0000);
            check_all("R5 sstat alias");
            wr(A_SSTAT, 1'b1, 64'h0000_0000_0380_0000);
            check_all("R6 guest via sstat-v");
            wr(A_GSTAT, 1'b0, 64'h0000_0000_0080_0000);
            check_all("R6 guest direct");
        end
        // R3: enable hypervisor, then drop the machine enable: reads zero, write ignored
        wr(A_MENV, 1'b0, 64'h1000_0000_0000_0000);
        wr(A_HENV, 1'b0, 64'h1000_0000_0000_0000);
        rd_chk("R3 henv set", A_HENV, 1'b0);
        wr(A_MENV, 1'b0, 64'h0);
        rd_chk("R3 henv masked", A_HENV, 1'b0);
        wr(A_HENV, 1'b0, 64'h0800_0000_0000_0000);
        wr(A_MENV, 1'b0, 64'h1000_0000_0000_0000);
        rd_chk("R3 henv write ignored", A_HENV, 1'b0);
        chk("R3 henv kept", model_read(A_HENV, 1'b0), 64'h1800_0000_0000_0000);
    endtask

    task automatic t_traps();
        wr(A_MENV, 1'b0, 64'h1000_0000_0000_0000);
        wr(A_HENV, 1'b0, 64'h1000_0000_0000_0000);
        trap(1'b1, 1'b0, 1'b1); rd_chk("R7 mtrap lp=1", A_MSTAT, 1'b0);
        trap(1'b1, 1'b0, 1'b0); rd_chk("R7 mtrap lp=0", A_MSTAT, 1'b0);
        trap(1'b0, 1'b0, 1'b1); rd_chk("R8 strap host", A_MSTAT, 1'b0);
        trap(1'b0, 1'b1, 1'b1); rd_chk("R8 strap guest", A_GSTAT, 1'b0);
        trap(1'b0, 1'b1, 1'b0); rd_chk("R8 strap guest clr", A_SSTAT, 1'b1);
        wr(A_HENV, 1'b0, 64'h0);
        trap(1'b0, 1'b1, 1'b1);
        wr(A_HENV, 1'b0, 64'h1000_0000_0000_0000);
        rd_chk("R8 guest trap gated", A_GSTAT, 1'b0);
        wr(A_MENV, 1'b0, 64'h0);
        trap(1'b0, 1'b0, 1'b0);
        wr(A_MENV, 1'b0, 64'h1000_0000_0000_0000);
        rd_chk("R8 host trap gated", A_MSTAT, 1'b0);
    endtask

    task automatic t_prio();
        wr(A_MENV, 1'b0, 64'h1000_0000_0000_0000);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = A_MSTAT; csr_virt = 1'b0;
        csr_wdata = 64'h0000_0000_0380_0000;
        trap_valid = 1'b1; trap_to_m = 1'b1; trap_virt = 1'b0; trap_lp_exp = 1'b1;
        @(negedge clk);
        csr_we = 1'b0; trap_valid = 1'b0;
        model_write(A_MSTAT, 1'b0, 64'h0000_0000_0380_0000, 1'b0, 1'b1, 1'b0);
        mp = 1'b1;
        rd_chk("R9 mtrap beats write", A_MSTAT, 1'b0);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = A_SSTAT; csr_virt = 1'b0;
        csr_wdata = 64'h0000_0000_0200_0000;
        trap_valid = 1'b1; trap_to_m = 1'b0; trap_virt = 1'b0; trap_lp_exp = 1'b0;
        @(negedge clk);
        csr_we = 1'b0; trap_valid = 1'b0;
        model_write(A_SSTAT, 1'b0, 64'h0000_0000_0200_0000, 1'b1, 1'b0, 1'b0);
        sp = 1'b0;
        rd_chk("R9 strap beats write", A_MSTAT, 1'b0);
    endtask

    task automatic t_msec();
        wr(A_MSEC, 1'b0, 64'h0000_0000_0000_0278);
        rd_chk("R10 msec legal", A_MSEC, 1'b0);
        chk("R10 msec value", model_read(A_MSEC, 1'b0), 64'h0000_0000_0000_0278);
        wr(A_MSEC, 1'b0, 64'h0000_0000_0000_0080);
        rd_chk("R10 msec illegal kept", A_MSEC, 1'b0);
        wr(A_MSEC, 1'b0, 64'h0000_0000_0000_01F8);
        rd_chk("R10 msec top illegal", A_MSEC, 1'b0);
    endtask

    task automatic t_unlisted();
        wr(A_JUNK, 1'b0, '1);
        rd_chk("R11 junk read", A_JUNK, 1'b0);
        check_all("R11 nothing changed");
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_menv();
        t_layers();
        t_traps();
        t_prio();
        t_msec();
        t_unlisted();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule